// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block steers four shared, level-sensitive PCI interrupt lines (PIRQ A to D) onto sixteen inputs of a legacy interrupt controller. Software programs one routing byte per PIRQ through a byte-wide configuration port. Each byte names the controller line that the PIRQ drives, or switches the PIRQ off. Each output line is the OR of every PIRQ input currently steered to it.

Internally the block keeps a 64-bit level vector with one bit per (line, PIRQ) pair, at bit index line×4 + pirq. A level change on a PIRQ updates only its own bit. A write to any routing byte clears the vector and rebuilds it from the present PIRQ levels and the new routing, so no stale bit is left on a line that a PIRQ has left. Two combinational helpers sit beside the router. A route query reports, for a given PIRQ, whether it is enabled and which line it drives. A slot swizzle maps a device's INTx pin and device/function number to the PIRQ that the pin is wired to.

Top module: `pirq_router`

## Requirements
- R1: After reset every routing byte reads 0x80, all sixteen outputs are low, and the route query reports every PIRQ disabled.
- R2: A routing value of 16 or more (for example 0x10, 0x80, 0xFF) disables its PIRQ. A disabled PIRQ drives no output, whatever its level.
- R3: The routing byte for PIRQ p (A=0 … D=3) sits at configuration offset 0x60+p. A read returns the written byte unchanged. A value below 16 routes the PIRQ to the output with that number.
- R4: Each output is high exactly when at least one PIRQ routed to it is high, including when several PIRQs share one line.
- R5: An output changes on the first rising clock edge after the PIRQ input change that causes it.
- R6: A routing write takes effect on the clock edge that accepts it. A PIRQ that is held high moves to its new line, and its old line drops in the same cycle unless another routed PIRQ still holds it.
- R7: Writes to offsets outside 0x60–0x63 change no routing byte and no output. Reads outside that range return 0.
- R8: The route query for PIRQ p returns enabled=1 and line = routing byte when the byte is below 16, and enabled=0 otherwise.
- R9: The swizzle returns PIRQ = (intx + (devfn >> 3) − 1) mod 4, with intx 0–3 meaning INTA–INTD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte (combinational on cfg_addr) |
| pirq_in | input | 4 | Active-high PIRQ levels, synchronous to clk |
| irq_out | output | 16 | Legacy interrupt line levels |
| qry_pirq | input | 2 | PIRQ selected for the route query |
| qry_enabled | output | 1 | Selected PIRQ is routed |
| qry_line | output | 4 | Line the selected PIRQ drives |
| swz_devfn | input | 8 | Device/function number for the swizzle |
| swz_intx | input | 2 | INTx pin of the device (0=INTA) |
| swz_pirq | output | 2 | PIRQ that the pin is wired to |

## Verification
The bench drives each PIRQ onto each of the sixteen lines in turn. A design that misindexes the level vector lights the wrong line or none. All four PIRQs are then routed to one shared line under every input pattern, which catches a design that drives the last writer's level in place of the OR. A held-high PIRQ is rerouted, and the check looks for a level left behind on its old line: an incremental update without the rebuild leaves one there. The disable threshold is probed at 15 against 16, 0x80 and 0xFF, where a sign or width slip shows as an enabled route. Writes at the neighbours of the routing window must be ignored, and the swizzle is swept over all 1024 input pairs, including device 0, where the subtraction wraps.

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int NUM_PIRQ  = 4,
  parameter int NUM_LINES = 16,
  parameter logic [7:0] BASE      = 8'h60,
  parameter logic [7:0] RST_ROUTE = 8'h80
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [7:0]                   cfg_addr,
  input  logic [7:0]                   cfg_wdata,
  output logic [7:0]                   cfg_rdata,
  input  logic [NUM_PIRQ-1:0]          pirq_in,
  output logic [NUM_LINES-1:0]         irq_out,
  input  logic [$clog2(NUM_PIRQ)-1:0]  qry_pirq,
  output logic                         qry_enabled,
  output logic [$clog2(NUM_LINES)-1:0] qry_line,
  input  logic [7:0]                   swz_devfn,
  input  logic [$clog2(NUM_PIRQ)-1:0]  swz_intx,
  output logic [$clog2(NUM_PIRQ)-1:0]  swz_pirq
);
  localparam int PW = $clog2(NUM_PIRQ);
  localparam int LW = $clog2(NUM_LINES);
  localparam int VW = NUM_LINES * NUM_PIRQ;
  localparam logic [7:0] LIMIT = 8'(NUM_LINES);
  localparam logic [7:0] TOP   = 8'(BASE + NUM_PIRQ);

  logic [NUM_PIRQ-1:0][7:0] route, route_nxt;
  logic [VW-1:0]            lvl, lvl_nxt;
  logic [NUM_PIRQ-1:0]      prev;
  logic                     in_rng, hit;
  logic [7:0]               off;

  assign in_rng = (cfg_addr >= BASE) && (cfg_addr < TOP);
  assign hit    = cfg_we && in_rng;
  assign off    = cfg_addr - BASE;

  always_comb begin
    route_nxt = route;
    if (hit) route_nxt[off[PW-1:0]] = cfg_wdata;
    lvl_nxt = lvl;
    if (hit) begin
      lvl_nxt = '0;
      for (int p = 0; p < NUM_PIRQ; p++)
        if (route_nxt[p] < LIMIT)
          lvl_nxt[{route_nxt[p][LW-1:0], PW'(p)}] = pirq_in[p];
    end else begin
      for (int p = 0; p < NUM_PIRQ; p++)
        if (pirq_in[p] != prev[p] && route[p] < LIMIT)
          lvl_nxt[{route[p][LW-1:0], PW'(p)}] = pirq_in[p];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      route <= {NUM_PIRQ{RST_ROUTE}};
      lvl   <= '0;
      prev  <= '0;
    end else begin
      route <= route_nxt;
      lvl   <= lvl_nxt;
      prev  <= pirq_in;
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign irq_out[l] = |lvl[l*NUM_PIRQ +: NUM_PIRQ];
  end

  assign cfg_rdata   = in_rng ? route[off[PW-1:0]] : 8'h00;
  assign qry_enabled = route[qry_pirq] < LIMIT;
  assign qry_line    = route[qry_pirq][LW-1:0];
  assign swz_pirq    = PW'(swz_intx + swz_devfn[3 +: PW] - PW'(1));

  function automatic logic [NUM_LINES-1:0] expect_out(
    input logic [NUM_PIRQ-1:0][7:0] rt, input logic [NUM_PIRQ-1:0] lv);
    logic [NUM_LINES-1:0] o;
    o = '0;
    for (int p = 0; p < NUM_PIRQ; p++)
      if (rt[p] < LIMIT && lv[p]) o[rt[p][LW-1:0]] = 1'b1;
    return o;
  endfunction

  // R4 R5 R6: outputs equal the OR of routed levels seen one edge earlier
  a_r4_or_of_routed: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == expect_out(route, $past(pirq_in)));

  // R2: with every PIRQ disabled no line is driven
  a_r2_all_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (route[0] >= LIMIT && route[1] >= LIMIT && route[2] >= LIMIT && route[3] >= LIMIT)
    |-> irq_out == '0);

  // R7: a write outside the window leaves the routing untouched
  a_r7_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !in_rng) |=> $stable(route));

  // R8: a disabled query never names a routed PIRQ
  a_r8_query_off: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_enabled |-> route[qry_pirq][7:LW] != '0);

  // R9: swizzle result shifts by one per device step
  always_comb begin
    if (rst_n)
      a_r9_swizzle: assert (((int'(swz_pirq) + 1) % NUM_PIRQ) ==
                            ((int'(swz_intx) + int'(swz_devfn >> 3)) % NUM_PIRQ));
  end
endmodule

// File: tb/pirq_router_test.sv
module pirq_router_test;
  logic       clk = 0, rst_n = 0;
  logic       cfg_we = 0;
  logic [7:0] cfg_addr = 0, cfg_wdata = 0, cfg_rdata;
  logic [3:0] pirq_in = 0;
  logic [15:0] irq_out;
  logic [1:0] qry_pirq = 0;
  logic       qry_enabled;
  logic [3:0] qry_line;
  logic [7:0] swz_devfn = 0;
  logic [1:0] swz_intx = 0, swz_pirq;

  int tests = 0, fails = 0;
  logic [7:0] rt [4];

  pirq_router uut (.*);

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [3:0] lv);
    logic [15:0] o = '0;
    for (int p = 0; p < 4; p++)
      if (rt[p] < 16 && lv[p]) o[rt[p][3:0]] = 1'b1;
    return o;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (a >= 8'h60 && a < 8'h64) rt[a - 8'h60] = d;
  endtask

  task automatic step(input logic [3:0] lv);
    pirq_in = lv;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++; tests++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int p = 0; p < 4; p++) rt[p] = 8'h80;
    pirq_in = 4'hF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 out", irq_out, 0);
    for (int p = 0; p < 4; p++) begin
      cfg_addr = 8'h60 + 8'(p); qry_pirq = 2'(p); #1;
      chk("R1 route", cfg_rdata, 8'h80);
      chk("R1 query", qry_enabled, 0);
    end
    // R3 R4 sweep each PIRQ over every line
    step(4'h0);
    for (int p = 0; p < 4; p++)
      for (int l = 0; l < 16; l++) begin
        wr(8'h60 + 8'(p), 8'(l));
        step(4'(1 << p));
        chk("R3 line", irq_out, 32'(1 << l));
        cfg_addr = 8'h60 + 8'(p); #1;
        chk("R3 readback", cfg_rdata, 32'(l));
        step(4'h0);
        chk("R3 drop", irq_out, 0);
        wr(8'h60 + 8'(p), 8'h80);
      end
    // R2 threshold
    foreach (rt[p]) ;
    step(4'hF);
    for (int p = 0; p < 4; p++) begin
      wr(8'h60 + 8'(p), 8'd15);
      chk("R2 value 15 enabled", irq_out, 32'h8000);
      qry_pirq = 2'(p); #1;
      chk("R8 query on", {qry_enabled, qry_line}, 5'h1F);
      wr(8'h60 + 8'(p), 8'h10);
      chk("R2 value 16 off", irq_out, 0);
      wr(8'h60 + 8'(p), 8'hFF);
      chk("R2 value FF off", irq_out, 0);
      #1 chk("R8 query off", qry_enabled, 0);
      wr(8'h60 + 8'(p), 8'h80);
    end
    // R4 all four on one shared line, every pattern
    step(4'h0);
    for (int p = 0; p < 4; p++) wr(8'h60 + 8'(p), 8'd5);
    for (int v = 0; v < 16; v++) begin
      step(4'(v));
      chk("R4 shared OR", irq_out, (v != 0) ? 32'h20 : 0);
    end
    // R4 distinct lines, every pattern
    wr(8'h60, 8'd1); wr(8'h61, 8'd3); wr(8'h62, 8'd3); wr(8'h63, 8'd12);
    for (int v = 0; v < 16; v++) begin
      step(4'(v));
      chk("R4 mixed", irq_out, model(4'(v)));
    end
    // R5 latency
    step(4'h0);
    pirq_in = 4'h1;
    @(posedge clk); #1;
    chk("R5 after edge", irq_out, 32'h2);
    @(negedge clk);
    pirq_in = 4'h0;
    #2 chk("R5 before edge", irq_out, 32'h2);
    @(negedge clk);
    chk("R5 fall", irq_out, 0);
    // R6 reroute held-high PIRQ
    step(4'h1);
    chk("R6 before", irq_out, 32'h2);
    cfg_we = 1; cfg_addr = 8'h60; cfg_wdata = 8'd9;
    @(posedge clk); #1;
    chk("R6 moved", irq_out, 32'h200);
    @(negedge clk); cfg_we = 0; rt[0] = 8'd9;
    step(4'h3);
    chk("R6 pair", irq_out, model(4'h3));
    wr(8'h61, 8'd9);
    chk("R6 old line drops", irq_out, 32'h200);
    wr(8'h60, 8'h80);
    chk("R6 shared held", irq_out, 32'h200);
    step(4'h0);
    chk("R6 clear", irq_out, 0);
    // R7 neighbours ignored
    wr(8'h60, 8'd2); wr(8'h61, 8'd4); wr(8'h62, 8'd6); wr(8'h63, 8'd8);
    step(4'hF);
    wr(8'h5F, 8'd0); wr(8'h64, 8'd0); wr(8'h00, 8'd0); wr(8'hE0, 8'd0);
    chk("R7 outputs", irq_out, 32'h154);
    for (int p = 0; p < 4; p++) begin
      cfg_addr = 8'h60 + 8'(p); #1;
      chk("R7 routes kept", cfg_rdata, 32'(2 * p + 2));
    end
    cfg_addr = 8'h5F; #1 chk("R7 read low", cfg_rdata, 0);
    cfg_addr = 8'h64; #1 chk("R7 read high", cfg_rdata, 0);
    // R8 query across values
    for (int p = 0; p < 4; p++) begin
      qry_pirq = 2'(p); #1;
      chk("R8 query", {qry_enabled, qry_line}, {1'b1, 4'(2 * p + 2)});
    end
    // R9 swizzle exhaustive
    for (int d = 0; d < 256; d++)
      for (int i = 0; i < 4; i++) begin
        swz_devfn = 8'(d); swz_intx = 2'(i); #1;
        chk("R9 swizzle", swz_pirq, 32'((i + (d >> 3) + 3) % 4));
      end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule